// File: doc/BRIEF.md
# DMA Transfer Chunking Engine

This block takes one DMA command and turns it into a series of memory requests. A command gives a direction (read or write), a start address, a byte length and, optionally, a stream ID and a substream ID. The engine cuts the transfer so that no request straddles a cache-line boundary. The first and last pieces may be short, and every full line in between becomes one request. Each request carries the byte offset of its data within the command, so a write-data source can present the right bytes. When the command supplies no IDs, every request of that command carries the default IDs held on the configuration pins.

Requests leave on a valid/ready channel. A request that is not accepted stays on the bus unchanged until the downstream side takes it, which is how a retry works, and the next chunk is not shown before then. Commands enter on a valid/ready channel too. `cmd_ready` is held low while the chunks of the current command are still being issued, and also while the completion queue already holds the maximum number of commands that are waiting for their responses. Responses are single-cycle pulses that the engine always accepts. They arrive in the order the requests were issued.

A counter of outstanding requests drives the `drained` status. When every chunk of a command has been answered, `done` pulses once for that command, after a programmable number of cycles. A command with zero length is accepted and then rejected with an error pulse.

Top module: `dma_chunker`

## Requirements
- R1: No request crosses a LINE_BYTES boundary. The first request runs from the start address up to the next boundary or to the end of the transfer, whichever comes first. Middle requests are full lines and the last one carries the remainder. `req_size` is the byte count (1..LINE_BYTES).
- R2: The first request address equals `cmd_addr`, and each later request address equals the previous address plus the previous size.
- R3: `req_doff` is 0 on the first request and grows by each issued request's size.
- R4: When `cmd_use_ids` is 1, the requests carry `cmd_sid`/`cmd_ssid`. When it is 0, they carry `cfg_def_sid`/`cfg_def_ssid` as sampled at command acceptance.
- R5: While `req_valid` is high and `req_ready` is low, the request fields stay stable and `req_valid` stays high. The next chunk appears only after a handshake.
- R6: `cmd_ready` is low from the acceptance of a non-zero command until the handshake of its last chunk, and it is low while CMD_DEPTH commands are awaiting responses.
- R7: A zero-length command produces a one-cycle `err_zero_len` pulse in the cycle after acceptance. It issues no request and raises no `done`.
- R8: `drained` is high exactly when no request is outstanding and no chunk remains to be issued. Each handshake adds one outstanding request and each `rsp_valid` removes one.
- R9: `done` pulses for one cycle once per non-zero command. If no earlier completion is pending, it goes high `cfg_done_delay`+1 clock edges after the edge that samples the command's last response.
- R10: `req_write` equals the `cmd_write` of the command being issued (1 = write, 0 = read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer start byte address |
| cmd_len | input | LEN_W | Transfer length in bytes |
| cmd_use_ids | input | 1 | Use command IDs instead of defaults |
| cmd_sid | input | SID_W | Command stream ID |
| cmd_ssid | input | SSID_W | Command substream ID |
| cfg_def_sid | input | SID_W | Default stream ID |
| cfg_def_ssid | input | SSID_W | Default substream ID |
| cfg_done_delay | input | DLY_W | Extra cycles before completion pulse |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Downstream accepts request |
| req_write | output | 1 | Request direction |
| req_addr | output | ADDR_W | Request byte address |
| req_size | output | $clog2(LINE_BYTES)+1 | Request byte count |
| req_doff | output | LEN_W | Byte offset of request data within the command |
| req_sid | output | SID_W | Request stream ID |
| req_ssid | output | SSID_W | Request substream ID |
| rsp_valid | input | 1 | One response pulse per request |
| done | output | 1 | Command completion pulse |
| err_zero_len | output | 1 | Zero-length command rejected |
| drained | output | 1 | No outstanding or unissued requests |

## Verification
The bench builds the engine with 16-byte lines, a 16-bit address, 12-bit lengths, a completion queue of two commands and a 4-bit delay field. The short line lets a 40-byte unaligned transfer produce a partial head, two full lines and a partial tail. The two-entry queue can be filled with two one-chunk commands, which shows `cmd_ready` held low by back-pressure from completions. The delay field reaches nonzero values, so the completion timing can be checked both with and without the extra wait.

// File: rtl/dma_chunker_pkg.sv
package dma_chunker_pkg;

  // bytes that fit from a line offset to the line end, capped by what remains
  function automatic int unsigned chunk_bytes(int unsigned off,
                                              int unsigned line,
                                              int unsigned rem);
    int unsigned room;
    room = line - off;
    return (rem < room) ? rem : room;
  endfunction

endpackage

// File: rtl/dma_chunk_gen.sv
module dma_chunk_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int SID_W      = 8,
  parameter int SSID_W     = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SZ_W      = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LEN_W-1:0]  st_len,
  input  logic              st_write,
  input  logic [SID_W-1:0]  st_sid,
  input  logic [SSID_W-1:0] st_ssid,
  input  logic              fire,
  output logic              active,
  output logic [ADDR_W-1:0] c_addr,
  output logic [SZ_W-1:0]   c_size,
  output logic [LEN_W-1:0]  c_doff,
  output logic              c_write,
  output logic [SID_W-1:0]  c_sid,
  output logic [SSID_W-1:0] c_ssid,
  output logic              last_fire,
  output logic [LEN_W-1:0]  chunk_total
);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, doff_q, nchunk_q;
  logic              is_last;

  always_comb begin
    c_size  = SZ_W'(dma_chunker_pkg::chunk_bytes(32'(addr_q[OFF_W-1:0]),
                                                 LINE_BYTES, 32'(rem_q)));
    is_last = (LEN_W'(c_size) == rem_q);
  end

  assign last_fire   = fire && is_last;
  assign chunk_total = nchunk_q + LEN_W'(1);
  assign c_addr      = addr_q;
  assign c_doff      = doff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      doff_q   <= '0;
      nchunk_q <= '0;
      c_write  <= 1'b0;
      c_sid    <= '0;
      c_ssid   <= '0;
    end else if (start) begin
      active   <= 1'b1;
      addr_q   <= st_addr;
      rem_q    <= st_len;
      doff_q   <= '0;
      nchunk_q <= '0;
      c_write  <= st_write;
      c_sid    <= st_sid;
      c_ssid   <= st_ssid;
    end else if (fire) begin
      addr_q   <= addr_q + ADDR_W'(c_size);
      rem_q    <= rem_q - LEN_W'(c_size);
      doff_q   <= doff_q + LEN_W'(c_size);
      nchunk_q <= nchunk_q + LEN_W'(1);
      if (is_last) active <= 1'b0;
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_last) |=> (addr_q == $past(addr_q) + ADDR_W'($past(c_size))));

  // R1
  size_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (c_size != '0));

endmodule

// File: rtl/dma_cmpl_track.sv
module dma_cmpl_track #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  parameter int DLY_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int QC_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CNT_W-1:0] push_total,
  input  logic             rsp,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             full,
  output logic             done
);

  logic [CNT_W-1:0] q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [QC_W-1:0]  qcnt;
  logic [CNT_W+1:0] rsp_cnt;
  logic [DLY_W-1:0] timer;
  logic             pop;

  assign full = (qcnt == QC_W'(DEPTH));
  assign pop  = (qcnt != '0) && (rsp_cnt >= (CNT_W+2)'(q[rd_ptr])) && (timer == '0);

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) q[wr_ptr] <= push_total;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      qcnt    <= '0;
      rsp_cnt <= '0;
      timer   <= '0;
      done    <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      qcnt    <= qcnt + QC_W'(push) - QC_W'(pop);
      rsp_cnt <= rsp_cnt + (CNT_W+2)'(rsp)
                 - (pop ? (CNT_W+2)'(q[rd_ptr]) : '0);
      done    <= 1'b0;
      if (timer != '0) begin
        timer <= timer - DLY_W'(1);
        if (timer == DLY_W'(1)) done <= 1'b1;
      end else if (pop) begin
        if (cfg_delay == '0) done <= 1'b1;
        else                 timer <= cfg_delay;
      end
    end
  end

  // R6
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

endmodule

// File: rtl/dma_chunker.sv
module dma_chunker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int SID_W      = 8,
  parameter int SSID_W     = 8,
  parameter int CMD_DEPTH  = 4,
  parameter int DLY_W      = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SZ_W      = OFF_W + 1,
  localparam int PEND_W    = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_use_ids,
  input  logic [SID_W-1:0]  cmd_sid,
  input  logic [SSID_W-1:0] cmd_ssid,
  input  logic [SID_W-1:0]  cfg_def_sid,
  input  logic [SSID_W-1:0] cfg_def_ssid,
  input  logic [DLY_W-1:0]  cfg_done_delay,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SZ_W-1:0]   req_size,
  output logic [LEN_W-1:0]  req_doff,
  output logic [SID_W-1:0]  req_sid,
  output logic [SSID_W-1:0] req_ssid,
  input  logic              rsp_valid,
  output logic              done,
  output logic              err_zero_len,
  output logic              drained
);

  logic             accept, start, fire, gen_active, last_fire, trk_full;
  logic [LEN_W-1:0] chunk_total;
  logic [PEND_W-1:0] pend_cnt;

  assign cmd_ready = !gen_active && !trk_full;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && (cmd_len != '0);
  assign req_valid = gen_active;
  assign fire      = req_valid && req_ready;

  dma_chunk_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES),
    .SID_W(SID_W), .SSID_W(SSID_W)
  ) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .st_addr    (cmd_addr),
    .st_len     (cmd_len),
    .st_write   (cmd_write),
    .st_sid     (cmd_use_ids ? cmd_sid  : cfg_def_sid),
    .st_ssid    (cmd_use_ids ? cmd_ssid : cfg_def_ssid),
    .fire       (fire),
    .active     (gen_active),
    .c_addr     (req_addr),
    .c_size     (req_size),
    .c_doff     (req_doff),
    .c_write    (req_write),
    .c_sid      (req_sid),
    .c_ssid     (req_ssid),
    .last_fire  (last_fire),
    .chunk_total(chunk_total)
  );

  dma_cmpl_track #(
    .CNT_W(LEN_W), .DEPTH(CMD_DEPTH), .DLY_W(DLY_W)
  ) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (last_fire),
    .push_total(chunk_total),
    .rsp       (rsp_valid),
    .cfg_delay (cfg_done_delay),
    .full      (trk_full),
    .done      (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt     <= '0;
      err_zero_len <= 1'b0;
    end else begin
      pend_cnt     <= pend_cnt + PEND_W'(fire) - PEND_W'(rsp_valid);
      err_zero_len <= accept && (cmd_len == '0);
    end
  end

  assign drained = (pend_cnt == '0) && !gen_active;

  // R1
  line_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (32'(req_addr[OFF_W-1:0]) + 32'(req_size) <= LINE_BYTES));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_size) && $stable(req_doff)));

  // R6
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);

  // R7
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero_len |-> !req_valid);

  // R8
  rsp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !drained);

endmodule

// File: tb/dma_chunker_test.sv
`timescale 1ns/1ps
module dma_chunker_test;
  localparam int ADDR_W = 16, LEN_W = 12, LINE = 16, SIDW = 4, SSIDW = 4;
  localparam int DEPTH = 2, DLYW = 4, SZW = $clog2(LINE) + 1;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0, cmd_use_ids = 0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic [SIDW-1:0]   cmd_sid = '0, cfg_def_sid = '0, req_sid;
  logic [SSIDW-1:0]  cmd_ssid = '0, cfg_def_ssid = '0, req_ssid;
  logic [DLYW-1:0]   cfg_done_delay = '0;
  logic req_ready = 1, rsp_valid = 0;
  logic cmd_ready, req_valid, req_write, done, err_zero_len, drained;
  logic [ADDR_W-1:0] req_addr;
  logic [SZW-1:0]    req_size;
  logic [LEN_W-1:0]  req_doff;

  int checks = 0, failures = 0, n_req = 0, done_cnt = 0;
  int m_addr [16], m_size [16], m_doff [16], m_sid [16], m_ssid [16], m_wr [16];

  always #4 clk = ~clk;

  dma_chunker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE), .SID_W(SIDW),
                .SSID_W(SSIDW), .CMD_DEPTH(DEPTH), .DLY_W(DLYW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_use_ids(cmd_use_ids), .cmd_sid(cmd_sid), .cmd_ssid(cmd_ssid),
    .cfg_def_sid(cfg_def_sid), .cfg_def_ssid(cfg_def_ssid),
    .cfg_done_delay(cfg_done_delay), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_doff(req_doff), .req_sid(req_sid), .req_ssid(req_ssid),
    .rsp_valid(rsp_valid), .done(done), .err_zero_len(err_zero_len),
    .drained(drained));

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && n_req < 16) begin
      m_addr[n_req] = int'(req_addr); m_size[n_req] = int'(req_size);
      m_doff[n_req] = int'(req_doff); m_sid[n_req] = int'(req_sid);
      m_ssid[n_req] = int'(req_ssid); m_wr[n_req] = int'(req_write);
      n_req = n_req + 1;
    end
    if (rst_n && done) done_cnt = done_cnt + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(bit wr, int addr, int len, bit use_ids, int sid, int ssid);
    cmd_write = wr; cmd_addr = ADDR_W'(addr); cmd_len = LEN_W'(len);
    cmd_use_ids = use_ids; cmd_sid = SIDW'(sid); cmd_ssid = SSIDW'(ssid);
    cmd_valid = 1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  task automatic wait_reqs(int n);
    for (int i = 0; i < 60 && n_req < n; i++) @(posedge clk);
    @(posedge clk); #1;
  endtask

  // sends n responses; returns edges from last sampled response to done
  task automatic send_rsp(int n, output int k);
    for (int i = 0; i < n; i++) begin
      rsp_valid = 1; @(posedge clk); #1 rsp_valid = 0;
    end
    k = 0;
    forever begin
      @(negedge clk);
      if (done || k > 40) break;
      @(posedge clk); k++;
    end
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R6 reset cmd_ready", int'(cmd_ready), 1);
    chk("R5 reset req_valid", int'(req_valid), 0);
    chk("R8 reset drained", int'(drained), 1);
    chk("R9 reset done", int'(done), 0);
    chk("R7 reset err", int'(err_zero_len), 0);
  endtask

  task automatic t_split;
    int k;
    n_req = 0; done_cnt = 0; req_ready = 1;
    do_cmd(1, 'h0A, 40, 1, 5, 9);
    wait_reqs(4);
    chk("R1 count", n_req, 4);
    chk("R2 addr0", m_addr[0], 'h0A); chk("R1 size0", m_size[0], 6);
    chk("R2 addr1", m_addr[1], 'h10); chk("R1 size1", m_size[1], 16);
    chk("R2 addr2", m_addr[2], 'h20); chk("R1 size2", m_size[2], 16);
    chk("R2 addr3", m_addr[3], 'h30); chk("R1 size3", m_size[3], 2);
    chk("R3 doff0", m_doff[0], 0);  chk("R3 doff1", m_doff[1], 6);
    chk("R3 doff3", m_doff[3], 38);
    chk("R4 sid", m_sid[2], 5); chk("R4 ssid", m_ssid[2], 9);
    chk("R10 write", m_wr[1], 1);
    @(negedge clk); chk("R8 busy not drained", int'(drained), 0);
    chk("R6 ready after issue", int'(cmd_ready), 1);
    @(posedge clk); #1;
    send_rsp(4, k);
    chk("R9 delay0 latency", k, 1);
    chk("R9 one done", done_cnt, 1);
    @(negedge clk); chk("R8 drained after", int'(drained), 1);
    @(posedge clk); #1;
  endtask

  task automatic t_defaults;
    int k;
    n_req = 0; done_cnt = 0;
    cfg_def_sid = 3; cfg_def_ssid = 7; cfg_done_delay = 3;
    do_cmd(0, 'h40, 16, 0, 12, 13);
    wait_reqs(1);
    chk("R1 aligned count", n_req, 1);
    chk("R1 aligned size", m_size[0], 16);
    chk("R4 default sid", m_sid[0], 3); chk("R4 default ssid", m_ssid[0], 7);
    chk("R10 read", m_wr[0], 0);
    send_rsp(1, k);
    chk("R9 delay3 latency", k, 4);
    chk("R9 one done delayed", done_cnt, 1);
    cfg_done_delay = 0;
  endtask

  task automatic t_stall;
    int k;
    n_req = 0; done_cnt = 0; req_ready = 0;
    do_cmd(1, 'h1C, 8, 1, 1, 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 held valid", int'(req_valid), 1);
      chk("R5 held addr", int'(req_addr), 'h1C);
      chk("R6 blocked", int'(cmd_ready), 0);
    end
    @(posedge clk); #1 req_ready = 1;
    wait_reqs(2);
    chk("R1 stall count", n_req, 2);
    chk("R1 stall size0", m_size[0], 4);
    chk("R2 stall addr1", m_addr[1], 'h20);
    chk("R3 stall doff1", m_doff[1], 4);
    send_rsp(2, k);
    chk("R9 stall done", done_cnt, 1);
  endtask

  task automatic t_zero;
    n_req = 0; done_cnt = 0;
    do_cmd(1, 'h50, 0, 1, 0, 0);
    chk("R7 err pulse", int'(err_zero_len), 1);
    @(posedge clk); #1;
    chk("R7 err one cycle", int'(err_zero_len), 0);
    repeat (6) @(posedge clk);
    #1;
    chk("R7 no request", n_req, 0);
    chk("R7 no done", done_cnt, 0);
    chk("R8 zero drained", int'(drained), 1);
  endtask

  task automatic t_queue;
    int k;
    n_req = 0; done_cnt = 0;
    do_cmd(1, 'h100, 4, 1, 0, 0);
    wait_reqs(1);
    do_cmd(1, 'h104, 4, 1, 0, 0);
    wait_reqs(2);
    @(negedge clk); chk("R6 queue full", int'(cmd_ready), 0);
    @(posedge clk); #1;
    send_rsp(1, k);
    chk("R9 first of two", done_cnt, 1);
    @(negedge clk); chk("R6 room again", int'(cmd_ready), 1);
    @(posedge clk); #1;
    send_rsp(1, k);
    chk("R9 second of two", done_cnt, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    @(posedge clk); #1;
    t_split;
    t_defaults;
    t_stall;
    t_zero;
    t_queue;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule